// File: doc/BRIEF.md
# Reset Request and Cause Recorder

This block lets software ask for a full-system reset and keeps a record of why the latest reset happened. Software writes a 4-bit request field through a simple write port. The field uses a redundant true/false encoding. Only the exact true pattern drives a request toward the power controller. When the controller reports that the reset has finished, the block returns the field to the false pattern by itself.

The same strobe also loads the cause register. Each active cause sets its bit: power-up, low-power exit, the software request, or one of the hardware requesters. Bits that are already set stay set. They clear only when software writes a 1 to them. The block's own reset is the always-on reset, so the cause bits survive the system reset they describe.

Top module: `rst_cause_rec`

## Requirements
- R1: After reset, the request field and `sw_rst_req_o` read 4'h9 (false) and the cause register reads 8'h01 (power-up bit set, all others clear).
- R2: A write with `wr_sel_i`=0 stores `wr_data_i[3:0]` in the request field. The new value is visible the cycle after the write. When that value is 4'h6 (true), `sw_rst_req_o` shows 4'h6 in the same cycle.
- R3: Any stored request pattern other than 4'h6 reads back unchanged, and `sw_rst_req_o` stays 4'h9.
- R4: The cycle after `rst_done_i` is high, the request field reads 4'h9. The completion strobe takes precedence over a request-field write in the same cycle.
- R5: On a cycle with `rst_done_i` high, cause bit 2 (software) is set if the request field holds 4'h6 at that moment. Otherwise bit 2 is left unchanged.
- R6: On a cycle with `rst_done_i` high, cause bit 0 is set if `por_i` is high, and cause bit 1 is set if `lpe_i` is high.
- R7: On a cycle with `rst_done_i` high, cause bit 3+i is set for each high bit `hw_req_i[i]`. The requesters are assigned as follows: bit 3 system reset controller, bit 4 watchdog, bit 5 main-power glitch, bit 6 alert escalation, bit 7 non-debug-module reset.
- R8: Cause bits that are already set stay set through later completions whose causes are inactive.
- R9: A write with `wr_sel_i`=1 clears each cause bit whose `wr_data_i` bit is 1. Bits written with 0 are unchanged.
- R10: If a completion sets a cause bit in the same cycle that software clears it, the bit ends up set.
- R11: Without `rst_done_i`, changes on `por_i`, `lpe_i` and `hw_req_i` leave the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low always-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 request field, 1 cause register |
| wr_data_i | input | 8 | Write data (request uses bits 3:0) |
| por_i | input | 1 | Power-up cause indication |
| lpe_i | input | 1 | Low-power-exit cause indication |
| rst_done_i | input | 1 | Reset completion strobe |
| hw_req_i | input | 5 | Hardware reset requester lines |
| sw_rst_req_o | output | 4 | Encoded request to the power controller |
| req_field_o | output | 4 | Readback of the request field |
| cause_o | output | 8 | Readback of the cause register |

## Verification
The bench writes near-miss request patterns such as 4'h5, 4'hE and 4'h3. A decoder that tested only some of the bits would raise a request on one of them. It times a completion together with a request write, where a design with the wrong priority would leave a live request behind. It also times a completion together with a write-1-to-clear of the same cause bit, where a design that lets the clear win would lose the cause. It toggles requester lines with no completion and issues completions with no causes active. Both expose cause bits that load without the strobe or get wiped on completion. Random traffic then mixes all of these against a bench model.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    localparam int REQ_W = 4;
    localparam logic [REQ_W-1:0] MUBI4_TRUE  = 4'h6;
    localparam logic [REQ_W-1:0] MUBI4_FALSE = 4'h9;

    localparam int CAUSE_POR     = 0;
    localparam int CAUSE_LPE     = 1;
    localparam int CAUSE_SW      = 2;
    localparam int CAUSE_HW_BASE = 3;

    typedef enum logic {
        SEL_REQ   = 1'b0,
        SEL_CAUSE = 1'b1
    } rrc_sel_e;
endpackage

// File: rtl/rrc_req_reg.sv
module rrc_req_reg
    import rrc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REQ_W-1:0] wr_data_i,
    input  logic             done_i,
    output logic [REQ_W-1:0] field_o,
    output logic [REQ_W-1:0] req_o,
    output logic             is_true_o
);
    typedef struct packed {
        logic [REQ_W-1:0] field;
    } req_state_t;

    req_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done_i) begin
            s_d.field = MUBI4_FALSE;
        end else if (wr_en_i) begin
            s_d.field = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.field <= MUBI4_FALSE;
        end else begin
            s_q <= s_d;
        end
    end

    assign field_o   = s_q.field;
    assign is_true_o = (s_q.field == MUBI4_TRUE);
    assign req_o     = is_true_o ? MUBI4_TRUE : MUBI4_FALSE;

    // R4
    done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> (field_o == MUBI4_FALSE && req_o == MUBI4_FALSE));

    // R2
    write_stores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !done_i) |=> (field_o == $past(wr_data_i)));

    // R3
    no_false_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !done_i && wr_data_i != MUBI4_TRUE) |=> (req_o == MUBI4_FALSE));
endmodule

// File: rtl/rrc_cause_reg.sv
module rrc_cause_reg
    import rrc_pkg::*;
#(
    parameter int NUM_HW  = 5,
    localparam int CW     = CAUSE_HW_BASE + NUM_HW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_en_i,
    input  logic [CW-1:0]     clr_data_i,
    input  logic              done_i,
    input  logic              por_i,
    input  logic              lpe_i,
    input  logic              sw_i,
    input  logic [NUM_HW-1:0] hw_i,
    output logic [CW-1:0]     cause_o
);
    localparam logic [CW-1:0] CAUSE_RST = CW'(1) << CAUSE_POR;

    typedef struct packed {
        logic [CW-1:0] cause;
    } cause_state_t;

    cause_state_t s_d, s_q;
    logic [CW-1:0] set_vec;
    logic [CW-1:0] clr_vec;

    assign set_vec[CAUSE_POR] = done_i & por_i;
    assign set_vec[CAUSE_LPE] = done_i & lpe_i;
    assign set_vec[CAUSE_SW]  = done_i & sw_i;

    for (genvar g = 0; g < NUM_HW; g++) begin : g_hw_set
        assign set_vec[CAUSE_HW_BASE + g] = done_i & hw_i[g];

        // R7
        hw_bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i && hw_i[g]) |=> cause_o[CAUSE_HW_BASE + g]);
    end

    assign clr_vec = clr_en_i ? clr_data_i : '0;

    always_comb begin
        s_d = s_q;
        s_d.cause = (s_q.cause & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cause <= CAUSE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign cause_o = s_q.cause;

    // R5
    sw_bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && sw_i) |=> cause_o[CAUSE_SW]);

    // R11
    no_set_without_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |=> ((cause_o & ~$past(cause_o)) == '0));

    // R9
    clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_en_i && !done_i) |=> ((cause_o & $past(clr_data_i)) == '0));

    // R8
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_en_i |=> ((~cause_o & $past(cause_o)) == '0));
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rrc_pkg::*;
#(
    parameter int NUM_HW_REQ = 5,
    localparam int CAUSE_W   = CAUSE_HW_BASE + NUM_HW_REQ
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic                  wr_sel_i,
    input  logic [CAUSE_W-1:0]    wr_data_i,
    input  logic                  por_i,
    input  logic                  lpe_i,
    input  logic                  rst_done_i,
    input  logic [NUM_HW_REQ-1:0] hw_req_i,
    output logic [REQ_W-1:0]      sw_rst_req_o,
    output logic [REQ_W-1:0]      req_field_o,
    output logic [CAUSE_W-1:0]    cause_o
);
    rrc_sel_e sel;
    logic     req_wr;
    logic     cause_clr;
    logic     sw_true;

    assign sel       = rrc_sel_e'(wr_sel_i);
    assign req_wr    = wr_en_i && (sel == SEL_REQ);
    assign cause_clr = wr_en_i && (sel == SEL_CAUSE);

    rrc_req_reg u_req (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (req_wr),
        .wr_data_i (wr_data_i[REQ_W-1:0]),
        .done_i    (rst_done_i),
        .field_o   (req_field_o),
        .req_o     (sw_rst_req_o),
        .is_true_o (sw_true)
    );

    rrc_cause_reg #(.NUM_HW(NUM_HW_REQ)) u_cause (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_en_i   (cause_clr),
        .clr_data_i (wr_data_i),
        .done_i     (rst_done_i),
        .por_i      (por_i),
        .lpe_i      (lpe_i),
        .sw_i       (sw_true),
        .hw_i       (hw_req_i),
        .cause_o    (cause_o)
    );

    // R10
    set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_done_i && cause_clr && hw_req_i[0]) |=> cause_o[CAUSE_HW_BASE]);
endmodule

// File: tb/rst_cause_rec_bench.sv
module rst_cause_rec_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       por = 1'b0;
    logic       lpe = 1'b0;
    logic       done = 1'b0;
    logic [4:0] hw = '0;
    logic [3:0] req_o;
    logic [3:0] field_o;
    logic [7:0] cause_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [3:0] m_field;
    logic [7:0] m_cause;

    always #2 clk = ~clk;

    rst_cause_rec u_rst_cause_rec (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .por_i        (por),
        .lpe_i        (lpe),
        .rst_done_i   (done),
        .hw_req_i     (hw),
        .sw_rst_req_o (req_o),
        .req_field_o  (field_o),
        .cause_o      (cause_o)
    );

    function automatic logic [3:0] exp_req(input logic [3:0] f);
        return (f == 4'h6) ? 4'h6 : 4'h9;
    endfunction

    function automatic logic [7:0] next_cause(input logic [7:0] c, input logic [3:0] f,
                                              input logic w, input logic s, input logic [7:0] d,
                                              input logic dn, input logic p, input logic l,
                                              input logic [4:0] h);
        logic [7:0] setv;
        logic [7:0] clrv;
        setv = dn ? {h, (f == 4'h6), l, p} : 8'h00;
        clrv = (w && s) ? d : 8'h00;
        return (c & ~clrv) | setv;
    endfunction

    function automatic logic [3:0] next_field(input logic [3:0] f, input logic w, input logic s,
                                              input logic [7:0] d, input logic dn);
        if (dn) return 4'h9;
        if (w && !s) return d[3:0];
        return f;
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "field", {4'h0, field_o}, {4'h0, m_field});
        check(tag, "req",   {4'h0, req_o},   {4'h0, exp_req(m_field)});
        check(tag, "cause", cause_o, m_cause);
    endtask

    task automatic step(input logic w, input logic s, input logic [7:0] d, input logic dn,
                        input logic p, input logic l, input logic [4:0] h, input string tag);
        wr_en = w; wr_sel = s; wr_data = d; done = dn; por = p; lpe = l; hw = h;
        @(posedge clk);
        m_cause = next_cause(m_cause, m_field, w, s, d, dn, p, l, h);
        m_field = next_field(m_field, w, s, d, dn);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_field = 4'h9;
        m_cause = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "field", {4'h0, field_o}, 8'h09);
        check("R1", "req",   {4'h0, req_o},   8'h09);
        check("R1", "cause", cause_o,         8'h01);

        step(1, 0, 8'h06, 0, 0, 0, 5'h00, "R2");
        check("R2", "req literal", {4'h0, req_o}, 8'h06);
        step(0, 0, 8'h00, 1, 0, 0, 5'h00, "R4 R5");
        check("R5", "cause literal", cause_o, 8'h05);
        step(1, 0, 8'h03, 0, 0, 0, 5'h00, "R3");
        step(1, 0, 8'h0E, 0, 0, 0, 5'h00, "R3");
        step(1, 0, 8'h05, 0, 0, 0, 5'h00, "R3");
        check("R3", "req literal", {4'h0, req_o}, 8'h09);
        step(0, 0, 8'h00, 1, 0, 0, 5'h00, "R5 R8");
        check("R8", "cause literal", cause_o, 8'h05);
        step(1, 1, 8'h00, 0, 0, 0, 5'h00, "R9");
        step(1, 1, 8'h04, 0, 0, 0, 5'h00, "R9");
        step(1, 1, 8'h01, 0, 0, 0, 5'h00, "R9");
        check("R9", "cause literal", cause_o, 8'h00);
        step(0, 0, 8'h00, 0, 1, 1, 5'h1F, "R11");
        check("R11", "cause literal", cause_o, 8'h00);
        step(0, 0, 8'h00, 1, 0, 0, 5'h02, "R7");
        check("R7", "watchdog bit", cause_o, 8'h10);
        step(0, 0, 8'h00, 1, 0, 0, 5'h10, "R7 R8");
        check("R7", "ndm bit", cause_o, 8'h90);
        step(0, 0, 8'h00, 1, 1, 1, 5'h00, "R6");
        check("R6", "por lpe bits", cause_o, 8'h93);
        step(1, 1, 8'hFF, 1, 0, 0, 5'h02, "R10");
        check("R10", "set wins", cause_o, 8'h10);
        step(1, 0, 8'h06, 0, 0, 0, 5'h00, "R2");
        step(1, 0, 8'h06, 1, 0, 0, 5'h00, "R4");
        check("R4", "done over write", {4'h0, field_o}, 8'h09);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            logic w, s, dn;
            logic [7:0] d;
            w  = ($urandom % 3) == 0;
            s  = $urandom % 2;
            d  = ($urandom % 4 == 0) ? 8'h06 : 8'($urandom);
            dn = ($urandom % 6) == 0;
            step(w, s, d, dn, $urandom % 2, $urandom % 2, 5'($urandom),
                 "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule